// File: doc/BRIEF.md
# Playback Start/Cancel Trigger Controller

This block owns the single run flag that launches and aborts a process executed by a separate playback engine. A 3-bit operating mode, loaded by the host, selects who may move the flag. The host can set or clear it by a register-style write. An external trigger pin, passed through a synchronizer and edge detector, can set it in edge fashion, where a repeated rising edge aborts an active run, or in level fashion, where the flag tracks the pin.

Every change of the flag reaches the engine as a one-cycle start or cancel pulse. The engine answers with a completion strobe, which clears the flag without a cancel. In the three streaming modes the pin carries data for the engine rather than a trigger, so neither pin edges nor host writes can raise the flag there. The self-test and tuning modes are started by the host and end on completion like any other run.

Top module: `trig_go_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the flag and the mode to 0, and no start or cancel pulse is issued while it is held.
- R2: In mode 0 (host) a host write of 1 while idle sets the flag and gives exactly one start pulse, and trigger pin edges leave the flag unchanged.
- R3: A host write of 0 while the flag is set clears the flag and gives exactly one cancel pulse.
- R4: In mode 1 (edge) a synchronized rising edge of the pin while idle sets the flag with one start pulse, and a falling edge has no effect.
- R5: In mode 1 a rising edge while the flag is still set clears it with one cancel pulse.
- R6: In mode 2 (level) a rising edge sets the flag with a start pulse and a falling edge clears it with a cancel pulse.
- R7: In mode 2 an edge that asks for the state the flag already holds produces no pulse and no change.
- R8: A completion strobe while the flag is set clears it without a cancel pulse, and a completion strobe while idle has no effect.
- R9: When a cancel request and a completion strobe arrive in the same cycle, the flag clears and no cancel pulse is issued.
- R10: In modes 3, 4 and 5 (streaming) neither pin edges nor host writes of 1 set the flag.
- R11: Modes 6 (self-test) and 7 (tuning) start on a host write of 1 and end when the completion strobe clears the flag.
- R12: A pin edge changes the flag on the clock edge `SYNC_STAGES`+1 after the pin changes, and not earlier.
- R13: Start and cancel are each one cycle wide and never high together; a start pulse appears only in the first cycle the flag is high, a cancel only in the first cycle it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_we | input | 1 | Load the mode from `mode_wdata` |
| mode_wdata | input | 3 | New mode value |
| go_we | input | 1 | Host write strobe for the run flag |
| go_wdata | input | 1 | Value written to the run flag |
| trig_pin | input | 1 | Asynchronous external trigger |
| eng_done | input | 1 | Engine completion strobe |
| go_o | output | 1 | Run flag |
| mode_o | output | 3 | Current mode |
| start_o | output | 1 | One-cycle start pulse to the engine |
| cancel_o | output | 1 | One-cycle cancel pulse to the engine |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 instead of the default 2, so the pin latency check sees a synchronizer deeper than the minimum and confirms the flag moves exactly one edge after the last stage and not before. With that depth, every mode is walked through its start, cancel, completion and ignored-edge cases. The same-cycle completion and cancel race and a reset during an active run are reached by directed sequences.

// File: rtl/go_ctrl_pkg.sv
package go_ctrl_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_HOST     = 3'd0,
        MODE_EDGE     = 3'd1,
        MODE_LEVEL    = 3'd2,
        MODE_STREAM_A = 3'd3,
        MODE_STREAM_B = 3'd4,
        MODE_STREAM_C = 3'd5,
        MODE_SELFTEST = 3'd6,
        MODE_TUNE     = 3'd7
    } mode_e;

    typedef struct packed {
        logic go;
        logic start;
        logic cancel;
    } go_state_t;

    // The pin feeds engine data in these modes, never the run flag.
    function automatic logic is_stream(input mode_e m);
        return (m == MODE_STREAM_A) || (m == MODE_STREAM_B) || (m == MODE_STREAM_C);
    endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    // Bits [STAGES-1:0] form the synchronizer; bit STAGES holds the prior sample.
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], pin};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/mode_reg.sv
module mode_reg
    import go_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MODE_W-1:0] wdata,
    output mode_e             mode
);
    mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (we) mode_d = mode_e'(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_HOST;
        else     mode_q <= mode_d;
    end

    assign mode = mode_q;

endmodule

// File: rtl/go_core.sv
module go_core
    import go_ctrl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  host_we,
    input  logic  host_val,
    input  logic  pin_rise,
    input  logic  pin_fall,
    input  logic  done,
    output logic  go,
    output logic  start,
    output logic  cancel
);
    go_state_t st_d, st_q;
    logic pin_set, pin_clr, host_set, host_clr, set_req, clr_req;

    always_comb begin
        pin_set = 1'b0;
        pin_clr = 1'b0;
        unique case (mode)
            MODE_EDGE: begin
                // Repeated rising edge toggles: start when idle, abort when busy.
                pin_set = pin_rise & ~st_q.go;
                pin_clr = pin_rise &  st_q.go;
            end
            MODE_LEVEL: begin
                pin_set = pin_rise;
                pin_clr = pin_fall;
            end
            default: ;
        endcase

        host_set = host_we &  host_val & ~is_stream(mode);
        host_clr = host_we & ~host_val;
        set_req  = host_set | pin_set;
        clr_req  = host_clr | pin_clr;

        st_d        = st_q;
        st_d.start  = 1'b0;
        st_d.cancel = 1'b0;
        if (st_q.go) begin
            if (done) begin
                st_d.go = 1'b0;            // completion wins over any cancel
            end else if (clr_req) begin
                st_d.go     = 1'b0;
                st_d.cancel = 1'b1;
            end
        end else if (set_req) begin
            st_d.go    = 1'b1;
            st_d.start = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign go     = st_q.go;
    assign start  = st_q.start;
    assign cancel = st_q.cancel;

endmodule

// File: rtl/trig_go_ctrl.sv
module trig_go_ctrl
    import go_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              go_we,
    input  logic              go_wdata,
    input  logic              trig_pin,
    input  logic              eng_done,
    output logic              go_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              start_o,
    output logic              cancel_o
);
    mode_e mode;
    logic  rise, fall;

    mode_reg u_mode (
        .clk   (clk),
        .rst   (rst),
        .we    (mode_we),
        .wdata (mode_wdata),
        .mode  (mode)
    );

    trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (trig_pin),
        .rise (rise),
        .fall (fall)
    );

    go_core u_core (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .host_we  (go_we),
        .host_val (go_wdata),
        .pin_rise (rise),
        .pin_fall (fall),
        .done     (eng_done),
        .go       (go_o),
        .start    (start_o),
        .cancel   (cancel_o)
    );

    assign mode_o = mode;

endmodule

// File: rtl/go_ctrl_chk.sv
module go_ctrl_chk
    import go_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              eng_done,
    input logic              go_o,
    input logic [MODE_W-1:0] mode_o,
    input logic              start_o,
    input logic              cancel_o
);
    // R13
    start_first_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(go_o) |-> start_o);

    // R13
    start_only_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |-> (go_o && !$past(go_o)));

    // R13
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_o && cancel_o));

    // R13
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    // R9
    cancel_vs_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(go_o) |-> (cancel_o == !$past(eng_done)));

    // R8
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (go_o && eng_done) |=> (!go_o && !cancel_o));

    // R10
    no_stream_start_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |-> !is_stream(mode_e'($past(mode_o))));

endmodule

bind trig_go_ctrl go_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .eng_done (eng_done),
    .go_o     (go_o),
    .mode_o   (mode_o),
    .start_o  (start_o),
    .cancel_o (cancel_o)
);

// File: tb/trig_go_ctrl_test.sv
module trig_go_ctrl_test;

    localparam int SYNC = 3;
    localparam int LAT  = SYNC + 1;
    localparam int NROW = 26;

    typedef struct packed {
        logic [2:0] mode;
        logic       gw;
        logic       gd;
        logic       trig;
        logic       done;
        logic       ego;
        logic [1:0] ns;
        logic [1:0] nc;
        logic [3:0] req;
    } row_t;

    // mode, host write, host value, pin level, done, expected flag, starts, cancels, requirement
    localparam row_t ROWS [NROW] = '{
        '{3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,4'd2},  // R2 pin ignored in host mode
        '{3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,4'd2},
        '{3'd0,1'b1,1'b1,1'b0,1'b0,1'b1,2'd1,2'd0,4'd2},  // R2 host start
        '{3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,2'd1,4'd3},  // R3 host cancel
        '{3'd1,1'b0,1'b0,1'b1,1'b0,1'b1,2'd1,2'd0,4'd4},  // R4 edge start
        '{3'd1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,2'd0,4'd4},  // R4 fall ignored
        '{3'd1,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,2'd1,4'd5},  // R5 second rise aborts
        '{3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,4'd4},
        '{3'd1,1'b0,1'b0,1'b1,1'b0,1'b1,2'd1,2'd0,4'd4},
        '{3'd1,1'b0,1'b0,1'b1,1'b1,1'b0,2'd0,2'd0,4'd8},  // R8 done clears
        '{3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,4'd4},
        '{3'd2,1'b0,1'b0,1'b1,1'b0,1'b1,2'd1,2'd0,4'd6},  // R6 level rise
        '{3'd2,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd1,4'd6},  // R6 level fall
        '{3'd2,1'b1,1'b1,1'b0,1'b0,1'b1,2'd1,2'd0,4'd6},
        '{3'd2,1'b0,1'b0,1'b1,1'b0,1'b1,2'd0,2'd0,4'd7},  // R7 already set
        '{3'd2,1'b0,1'b0,1'b1,1'b1,1'b0,2'd0,2'd0,4'd8},
        '{3'd2,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,4'd7},  // R7 already clear
        '{3'd3,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,4'd10}, // R10 streaming
        '{3'd4,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,4'd10},
        '{3'd5,1'b1,1'b1,1'b1,1'b0,1'b0,2'd0,2'd0,4'd10},
        '{3'd5,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,4'd10},
        '{3'd6,1'b1,1'b1,1'b0,1'b0,1'b1,2'd1,2'd0,4'd11}, // R11 self-test
        '{3'd6,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,2'd0,4'd11},
        '{3'd7,1'b1,1'b1,1'b0,1'b0,1'b1,2'd1,2'd0,4'd11}, // R11 tuning
        '{3'd7,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,2'd0,4'd11},
        '{3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,2'd0,4'd8}   // R8 done while idle
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_we = 1'b0;
    logic [2:0] mode_wdata = 3'd0;
    logic       go_we = 1'b0;
    logic       go_wdata = 1'b0;
    logic       trig_pin = 1'b0;
    logic       eng_done = 1'b0;
    logic       go_o, start_o, cancel_o;
    logic [2:0] mode_o;

    int checks = 0;
    int fails  = 0;
    int n_start = 0;
    int n_cancel = 0;

    always #10 clk = ~clk;

    trig_go_ctrl #(.SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .go_we(go_we), .go_wdata(go_wdata), .trig_pin(trig_pin), .eng_done(eng_done),
        .go_o(go_o), .mode_o(mode_o), .start_o(start_o), .cancel_o(cancel_o)
    );

    always @(negedge clk) begin
        if (start_o)  n_start  <= n_start + 1;
        if (cancel_o) n_cancel <= n_cancel + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic run_row(input row_t r, input int idx);
        set_mode(r.mode);
        n_start = 0; n_cancel = 0;
        go_we = r.gw; go_wdata = r.gd; trig_pin = r.trig; eng_done = r.done;
        @(negedge clk);
        go_we = 1'b0; eng_done = 1'b0;
        repeat (LAT) @(negedge clk);
        chk($sformatf("R%0d row %0d flag", r.req, idx), go_o, r.ego);
        chk($sformatf("R%0d row %0d starts", r.req, idx), n_start, r.ns);
        chk($sformatf("R%0d row %0d cancels", r.req, idx), n_cancel, r.nc);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 flag after reset", go_o, 0);
        chk("R1 mode after reset", mode_o, 0);
        chk("R1 no pulses in reset", start_o | cancel_o, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NROW; i++) run_row(ROWS[i], i);

        // R12 pin latency is SYNC+1 edges
        set_mode(3'd1);
        trig_pin = 1'b1;
        repeat (SYNC) @(negedge clk);
        chk("R12 flag not yet set", go_o, 0);
        @(negedge clk);
        chk("R12 flag set on edge SYNC+1", go_o, 1);
        chk("R13 start pulse present", start_o, 1);
        @(negedge clk);
        chk("R13 start pulse one cycle", start_o, 0);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0; trig_pin = 1'b0;
        repeat (LAT) @(negedge clk);

        // R9 done and host cancel in the same cycle
        set_mode(3'd0);
        go_we = 1'b1; go_wdata = 1'b1;
        @(negedge clk);
        go_we = 1'b0;
        chk("R9 setup flag", go_o, 1);
        n_cancel = 0;
        go_we = 1'b1; go_wdata = 1'b0; eng_done = 1'b1;
        @(negedge clk);
        go_we = 1'b0; eng_done = 1'b0;
        @(negedge clk);
        chk("R9 flag cleared", go_o, 0);
        chk("R9 no cancel", n_cancel, 0);

        // R1 reset during an active run
        set_mode(3'd6);
        go_we = 1'b1; go_wdata = 1'b1;
        @(negedge clk);
        go_we = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset clears active flag", go_o, 0);
        chk("R1 reset clears mode", mode_o, 0);
        rst = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule